// File: doc/BRIEF.md
# Bit-Serial Parallel Max/Min Selector

This block finds the largest or the smallest of N unsigned words. It does not use a comparator tree. It scans all N words together, one bit position per clock, from the most significant bit down to the least significant bit. Each word has a small elimination cell that holds a one-bit "still in the running" flag. One wide OR gathers the current bits of the words still in the running and feeds the result back to every cell. When that OR is high, any surviving word whose current bit is low drops out. Minimum selection uses the same hardware with the scanned bits inverted.

A scan begins with a one-cycle start pulse. On that edge the block captures the words and the mode, sets every flag and points at the top bit. The input words may therefore change while the scan runs. After one cycle per bit, a one-cycle done pulse presents three registered results:
- the flag vector, which marks every word equal to the extreme value;
- the index of the lowest-numbered marked word;
- that word's value.

These outputs hold until the next done. A new start during a scan abandons the scan in progress and begins again.

Top module: `maxmin_select`

## Requirements
- R1: While reset is high and after it is released, done_o, labels_o, win_idx_o and win_val_o are all 0 until the first scan completes.
- R2: The words and the mode are captured on the clock edge where start_i is high. Changes to words_i or min_mode_i after that edge do not alter the result of that scan.
- R3: With min_mode_i = 0 (maximum), bit i of labels_o at done is 1 exactly when word i equals the largest of the captured words. Word i occupies words_i[i*WORD_W +: WORD_W]. Ties leave several bits set.
- R4: With min_mode_i = 1 (minimum), bit i of labels_o at done is 1 exactly when word i equals the smallest captured word. Ties leave several bits set.
- R5: done_o is high for exactly one cycle. Counting the start edge as edge 0, it rises on edge WORD_W+1 and falls on the following edge.
- R6: At done, win_idx_o is the lowest index whose bit in labels_o is set, and win_val_o equals the captured word at that index.
- R7: A start pulse during a scan, including one on the scan's last bit edge, abandons that scan. No done is produced for the abandoned scan. The single done that follows reflects the words present on the new start edge and follows R5 timing from that edge.
- R8: During a scan a flag never goes from 0 back to 1, and at least one flag always stays set.
- R9: labels_o, win_idx_o and win_val_o change only on the edge that raises done_o. Between done pulses they hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse that captures words and mode |
| min_mode_i | input | 1 | 0 selects maximum, 1 selects minimum |
| words_i | input | N_WORDS*WORD_W | Packed input words, word i at bits i*WORD_W upward |
| done_o | output | 1 | One-cycle pulse when results are valid |
| labels_o | output | N_WORDS | Flag per word: 1 if the word equals the extreme value |
| win_idx_o | output | $clog2(N_WORDS) | Lowest index among flagged words |
| win_val_o | output | WORD_W | Value of the winning word |

## Verification
The hardest case to reach from the ports is a restart on the last bit edge of a running scan. In that case the old scan is one edge away from reporting, and a missed cancellation would raise a stray done. The bench aims a second start at exactly that edge and at a mid-scan edge. It then checks that done stays low until the new scan's own deadline. It also scrambles words_i and min_mode_i on every cycle of a scan, and draws words from narrow ranges so that multi-way ties are frequent.

// File: rtl/mms_pkg.sv
package mms_pkg;
  typedef enum logic {
    SEL_MAX = 1'b0,
    SEL_MIN = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/mms_label_unit.sv
module mms_label_unit
  import mms_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  sel_mode_e         mode,
  input  logic [WORD_W-1:0] word_in,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              gor,
  output logic              label,
  output logic              cand,
  output logic [WORD_W-1:0] word_q
);
  logic bit_s;

  // inverting the scanned bit turns minimum search into maximum search
  assign bit_s = word_q[ptr] ^ (mode == SEL_MIN);
  assign cand  = label & bit_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      label  <= 1'b0;
      word_q <= '0;
    end else if (load) begin
      label  <= 1'b1;
      word_q <= word_in;
    end else if (run) begin
      label  <= label & (bit_s | ~gor);
    end
  end

  // R8: a dropped word never comes back without a new start
  p_label_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !label) |=> !label);

  // R3/R4: a surviving word with a 0 bit drops out when another survivor has a 1
  p_drop_on_loss_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !load && label && !bit_s && gor) |=> !label);
endmodule

// File: rtl/mms_global_or.sv
module mms_global_or #(
  parameter int N_WORDS = 8
) (
  input  logic [N_WORDS-1:0] cand,
  output logic               gor
);
  assign gor = |cand;
endmodule

// File: rtl/mms_first_set.sv
module mms_first_set #(
  parameter int N_WORDS = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_WORDS-1:0] vec,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = N_WORDS - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/maxmin_select.sv
module maxmin_select
  import mms_pkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic                        min_mode_i,
  input  logic [N_WORDS*WORD_W-1:0]   words_i,
  output logic                        done_o,
  output logic [N_WORDS-1:0]          labels_o,
  output logic [$clog2(N_WORDS)-1:0]  win_idx_o,
  output logic [WORD_W-1:0]           win_val_o
);
  localparam int IDX_W = $clog2(N_WORDS);
  localparam int PTR_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(WORD_W - 1);

  logic              busy_q, fin_q;
  logic [PTR_W-1:0]  ptr_q;
  sel_mode_e         mode_q;
  logic [N_WORDS-1:0] labels, cand;
  logic              gor;
  logic [IDX_W-1:0]  first_idx;
  logic [WORD_W-1:0] word_arr [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_unit
    mms_label_unit #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_unit (
      .clk     (clk),
      .rst     (rst),
      .load    (start_i),
      .run     (busy_q),
      .mode    (mode_q),
      .word_in (words_i[g*WORD_W +: WORD_W]),
      .ptr     (ptr_q),
      .gor     (gor),
      .label   (labels[g]),
      .cand    (cand[g]),
      .word_q  (word_arr[g])
    );
  end

  mms_global_or #(.N_WORDS(N_WORDS)) u_gor (
    .cand (cand),
    .gor  (gor)
  );

  mms_first_set #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_first (
    .vec (labels),
    .idx (first_idx)
  );

  // scan control: start has priority and cancels any pending result
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      ptr_q  <= '0;
      mode_q <= SEL_MAX;
    end else if (start_i) begin
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
      ptr_q  <= PTR_TOP;
      mode_q <= sel_mode_e'(min_mode_i);
    end else if (busy_q) begin
      ptr_q <= ptr_q - 1'b1;
      if (ptr_q == '0) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      labels_o  <= '0;
      win_idx_o <= '0;
      win_val_o <= '0;
    end else begin
      done_o <= fin_q;
      if (fin_q) begin
        labels_o  <= labels;
        win_idx_o <= first_idx;
        win_val_o <= word_arr[first_idx];
      end
    end
  end

  // R5: done lasts one cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: some word always survives a scan step
  p_survivor_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !start_i) |=> (labels != '0));

  // R6: the reported index carries a set flag
  p_winner_flagged_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> labels_o[win_idx_o]);

  // R9: results hold between done pulses
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(labels_o) && $stable(win_idx_o) && $stable(win_val_o)));
endmodule

// File: tb/test_maxmin_select.sv
module test_maxmin_select;
  localparam int N = 8;
  localparam int W = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic min_mode_i = 1'b0;
  logic [N*W-1:0] words_i = '0;
  logic done_o;
  logic [N-1:0] labels_o;
  logic [IW-1:0] win_idx_o;
  logic [W-1:0] win_val_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  maxmin_select #(.N_WORDS(N), .WORD_W(W)) i_maxmin_select (
    .clk(clk), .rst(rst), .start_i(start_i), .min_mode_i(min_mode_i),
    .words_i(words_i), .done_o(done_o), .labels_o(labels_o),
    .win_idx_o(win_idx_o), .win_val_o(win_val_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ext_val(input logic [N*W-1:0] w, input bit mn);
    logic [W-1:0] e = w[W-1:0];
    for (int i = 1; i < N; i++) begin
      if (mn ? (w[i*W +: W] < e) : (w[i*W +: W] > e)) e = w[i*W +: W];
    end
    return e;
  endfunction

  function automatic logic [N-1:0] exp_labels(input logic [N*W-1:0] w, input bit mn);
    logic [N-1:0] l = '0;
    logic [W-1:0] e = ext_val(w, mn);
    for (int i = 0; i < N; i++) l[i] = (w[i*W +: W] == e);
    return l;
  endfunction

  function automatic logic [IW-1:0] exp_idx(input logic [N-1:0] l);
    for (int i = 0; i < N; i++) if (l[i]) return IW'(i);
    return '0;
  endfunction

  function automatic logic [N*W-1:0] rnd_words(input int kind);
    logic [N*W-1:0] w;
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: w[i*W +: W] = W'($urandom);
        1: w[i*W +: W] = W'($urandom % 4);
        default: w[i*W +: W] = W'(8'hF0 | ($urandom % 3));
      endcase
    end
    return w;
  endfunction

  // checks results of a scan whose start edge has just passed (now at first negedge after it)
  task automatic finish_scan(input logic [N*W-1:0] w, input bit mn, input bit scramble);
    logic [N-1:0] el = exp_labels(w, mn);
    logic [IW-1:0] ei = exp_idx(el);
    logic [N-1:0] pl = labels_o;
    for (int k = 1; k <= W; k++) begin
      if (scramble) begin
        words_i = rnd_words(0);
        min_mode_i = 1'($urandom);
      end
      @(negedge clk);
      chk(done_o == 1'b0, "R5 early done", done_o, 0);
      chk(labels_o == pl, "R9 hold", labels_o, pl);
    end
    @(negedge clk);
    chk(done_o == 1'b1, "R5 done timing", done_o, 1);
    chk(labels_o == el, mn ? "R4 min labels" : "R3 max labels", labels_o, el);
    chk(win_idx_o == ei, "R6 index", win_idx_o, ei);
    chk(win_val_o == w[ei*W +: W], scramble ? "R2 R6 value" : "R6 value", win_val_o, w[ei*W +: W]);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 single pulse", done_o, 0);
    chk(labels_o == el, "R9 hold after done", labels_o, el);
  endtask

  task automatic scan(input logic [N*W-1:0] w, input bit mn, input bit scramble);
    words_i = w;
    min_mode_i = mn;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_scan(w, mn, scramble);
  endtask

  // start, then restart after 'gap' more edges
  task automatic restart(input int gap, input logic [N*W-1:0] w2, input bit mn2);
    words_i = rnd_words(0);
    min_mode_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R7 no done before restart", done_o, 0);
    end
    words_i = w2;
    min_mode_i = mn2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_scan(w2, mn2, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (2) @(negedge clk);
    chk(done_o == 0 && labels_o == 0, "R1 in reset", {done_o, labels_o}, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o == 0 && labels_o == 0 && win_idx_o == 0 && win_val_o == 0,
        "R1 after reset", {done_o, labels_o, win_idx_o, win_val_o}, 0);

    // directed corners
    scan('0, 1'b0, 1'b0);                         // R3 all equal: every flag
    scan({N*W{1'b1}}, 1'b1, 1'b0);                // R4 all ones min
    scan({8'd5, 8'd9, 8'd1, 8'd9, 8'd0, 8'd3, 8'd9, 8'd2}, 1'b0, 1'b0); // R3 ties at top
    scan({8'd5, 8'd9, 8'd1, 8'd9, 8'd0, 8'd3, 8'd0, 8'd2}, 1'b1, 1'b0); // R4 ties at zero
    scan({8'h80, {(N-1){8'h7F}}}, 1'b0, 1'b0);    // R3 msb decides, winner at top index
    scan({8'h7F, {(N-1){8'h80}}}, 1'b1, 1'b1);    // R2 R4 with scrambled inputs
    restart(3, {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8}, 1'b1); // R7 mid scan
    restart(W - 1, {8'd9, 8'd2, 8'd9, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8}, 1'b0); // R7 last bit edge

    // random mix
    for (int t = 0; t < 60; t++) begin
      scan(rnd_words(t % 3), 1'($urandom), 1'(t % 2));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule